// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This unit resolves the control flow of one RV32I instruction in a single combinational pass. It receives the address of the current instruction, the instruction word and the two source register values. From these it decides whether control leaves the sequential path, and it produces the address of the next instruction. It also produces the return address that a jump writes to its destination register.

Conditional branches compare the two source values in one of three ways: equality, signed order or unsigned order. A taken branch or a direct jump adds an offset that is scattered across the instruction word and counted in half-words to the current address. A register-indirect jump instead adds a byte-granular 12-bit offset to the first source value and forces the result even. Every other instruction, and every branch that is not taken, continues at the current address plus four.

The unit sits between operand fetch and the program-counter register of a single-cycle or pipelined core. It holds no state, so its result is valid in the same cycle as its inputs.

Top module: `bnpc_unit`

## Requirements
- R1: For opcode 1100011 with funct3 (bits 14:12) 000 the branch is taken when rs1 equals rs2, and with funct3 001 when they differ.
- R2: With funct3 100 the branch is taken when rs1 is less than rs2 as two's-complement values, and with 101 when rs1 is greater than or equal to rs2 as two's-complement values.
- R3: With funct3 110 the branch is taken when rs1 is below rs2 as unsigned values, and with 111 when rs1 is at or above rs2 as unsigned values.
- R4: A taken branch sets next_pc to pc plus the sign-extended 13-bit offset {instr[31], instr[7], instr[30:25], instr[11:8], 0}, with wrap-around modulo 2^XLEN.
- R5: Opcode 1101111 is always taken, and next_pc is pc plus the sign-extended 21-bit offset {instr[31], instr[19:12], instr[20], instr[30:21], 0}, which spans -1 MiB to +1 MiB-2.
- R6: Opcode 1100111 is always taken, and next_pc is rs1 plus the sign-extended 12-bit instr[31:20], with bit 0 of the sum forced to zero.
- R7: link_pc equals pc plus 4, modulo 2^XLEN, for every instruction.
- R8: A branch that is not taken, a branch with the reserved funct3 010 or 011, and any other opcode give next_pc = pc + 4 with taken low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs1_i | input | XLEN | First source register value |
| rs2_i | input | XLEN | Second source register value |
| next_pc_o | output | XLEN | Address of the next instruction |
| taken_o | output | 1 | High when control leaves the sequential path |
| link_pc_o | output | XLEN | Return address, pc + 4 |

## Verification
The unit holds no state, so a wrong comparison outcome or a misplaced offset bit shows at next_pc_o and taken_o in the same cycle as the input that triggers it. Operand pairs that straddle the sign boundary make the signed and unsigned orderings disagree, and they expose a swapped comparison at once. Offsets at the extremes of each immediate format expose a dropped or shuffled offset bit as a target that is off by a power of two. A randomised stream is compared against an arithmetic model on every clock.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  // Major opcodes that redirect control flow
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  // Branch condition selectors (funct3)
  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_JAL  = 2'd2,
    FLOW_JALR = 2'd3
  } flow_e;

  // Conditional-branch offset, half-word scaled (bit 0 implicit zero)
  function automatic logic [12:0] br_offset(input logic [31:0] w);
    return {w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  // Direct-jump offset, half-word scaled (bit 0 implicit zero)
  function automatic logic [20:0] jal_offset(input logic [31:0] w);
    return {w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  // Register-indirect jump offset, byte granular
  function automatic logic [11:0] jalr_offset(input logic [31:0] w);
    return w[31:20];
  endfunction

  function automatic flow_e classify(input logic [6:0] opc);
    case (opc)
      OPC_BRANCH: return FLOW_BR;
      OPC_JAL:    return FLOW_JAL;
      OPC_JALR:   return FLOW_JALR;
      default:    return FLOW_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output flow_e           flow_o,
  output logic [2:0]      cond_sel_o,
  output logic [XLEN-1:0] off_br_o,
  output logic [XLEN-1:0] off_jal_o,
  output logic [XLEN-1:0] off_jalr_o
);

  localparam int BR_W   = 13;
  localparam int JAL_W  = 21;
  localparam int JALR_W = 12;

  logic [BR_W-1:0]   br_raw;
  logic [JAL_W-1:0]  jal_raw;
  logic [JALR_W-1:0] jalr_raw;

  always_comb begin
    br_raw     = br_offset(instr_i);
    jal_raw    = jal_offset(instr_i);
    jalr_raw   = jalr_offset(instr_i);
    flow_o     = classify(instr_i[6:0]);
    cond_sel_o = instr_i[14:12];
  end

  assign off_br_o   = {{(XLEN-BR_W){br_raw[BR_W-1]}},       br_raw};
  assign off_jal_o  = {{(XLEN-JAL_W){jal_raw[JAL_W-1]}},    jal_raw};
  assign off_jalr_o = {{(XLEN-JALR_W){jalr_raw[JALR_W-1]}}, jalr_raw};

endmodule

// File: rtl/bnpc_compare.sv
module bnpc_compare
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [2:0]      sel_i,
  output logic            eq_o,
  output logic            lt_s_o,
  output logic            lt_u_o,
  output logic            cond_o
);

  assign eq_o   = (a_i == b_i);
  assign lt_u_o = (a_i < b_i);
  assign lt_s_o = ($signed(a_i) < $signed(b_i));

  always_comb begin
    case (sel_i)
      CMP_EQ:  cond_o = eq_o;
      CMP_NE:  cond_o = !eq_o;
      CMP_LT:  cond_o = lt_s_o;
      CMP_GE:  cond_o = !lt_s_o;
      CMP_LTU: cond_o = lt_u_o;
      CMP_GEU: cond_o = !lt_u_o;
      default: cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  flow_e           flow_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] off_br_i,
  input  logic [XLEN-1:0] off_jal_i,
  input  logic [XLEN-1:0] off_jalr_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] link_o
);

  localparam logic [XLEN-1:0] STEP      = XLEN'(4);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jal_pc;
  logic [XLEN-1:0] jalr_sum;

  assign seq_pc   = pc_i + STEP;
  assign br_pc    = pc_i + off_br_i;
  assign jal_pc   = pc_i + off_jal_i;
  assign jalr_sum = rs1_i + off_jalr_i;
  assign link_o   = seq_pc;

  always_comb begin
    case (flow_i)
      FLOW_BR: begin
        taken_o   = cond_i;
        next_pc_o = cond_i ? br_pc : seq_pc;
      end
      FLOW_JAL: begin
        taken_o   = 1'b1;
        next_pc_o = jal_pc;
      end
      FLOW_JALR: begin
        taken_o   = 1'b1;
        next_pc_o = jalr_sum & EVEN_MASK;
      end
      default: begin
        taken_o   = 1'b0;
        next_pc_o = seq_pc;
      end
    endcase
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] link_pc_o
);

  flow_e           flow;
  logic [2:0]      cond_sel;
  logic [XLEN-1:0] off_br;
  logic [XLEN-1:0] off_jal;
  logic [XLEN-1:0] off_jalr;
  logic            ops_eq;
  logic            ops_lt_s;
  logic            ops_lt_u;
  logic            cond_hit;

  bnpc_decode #(.XLEN(XLEN)) u_decode (
    .instr_i    (instr_i),
    .flow_o     (flow),
    .cond_sel_o (cond_sel),
    .off_br_o   (off_br),
    .off_jal_o  (off_jal),
    .off_jalr_o (off_jalr)
  );

  bnpc_compare #(.XLEN(XLEN)) u_compare (
    .a_i    (rs1_i),
    .b_i    (rs2_i),
    .sel_i  (cond_sel),
    .eq_o   (ops_eq),
    .lt_s_o (ops_lt_s),
    .lt_u_o (ops_lt_u),
    .cond_o (cond_hit)
  );

  bnpc_target #(.XLEN(XLEN)) u_target (
    .pc_i       (pc_i),
    .rs1_i      (rs1_i),
    .flow_i     (flow),
    .cond_i     (cond_hit),
    .off_br_i   (off_br),
    .off_jal_i  (off_jal),
    .off_jalr_i (off_jalr),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_o     (link_pc_o)
  );

  always_comb begin
    // R8
    if (!taken_o) begin
      seq_when_idle_chk: assert (next_pc_o == link_pc_o);
    end
    // R8
    if (flow == FLOW_SEQ) begin
      plain_op_not_taken_chk: assert (!taken_o);
    end
    // R5
    if (flow == FLOW_JAL || flow == FLOW_JALR) begin
      jump_always_taken_chk: assert (taken_o);
    end
    // R6
    if (flow == FLOW_JALR) begin
      jalr_even_target_chk: assert (next_pc_o[0] == 1'b0);
    end
    // R1
    if (ops_eq) begin
      equal_excludes_less_chk: assert (!ops_lt_s && !ops_lt_u);
    end
    // R2
    if (ops_lt_s != ops_lt_u) begin
      order_split_needs_sign_chk: assert (rs1_i[XLEN-1] != rs2_i[XLEN-1]);
    end
  end

endmodule

// File: tb/bnpc_unit_tb.sv
module bnpc_unit_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] pc, rs1, rs2;
  logic [31:0]  ins;
  logic [W-1:0] next_pc, link_pc;
  logic         taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bnpc_unit #(.XLEN(W)) u_dut (
    .pc_i      (pc),
    .instr_i   (ins),
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .next_pc_o (next_pc),
    .taken_o   (taken),
    .link_pc_o (link_pc)
  );

  // ---- instruction builders (inverse of the field layouts in R4..R6)
  function automatic logic [31:0] mk_br(input logic [2:0] f3, input longint off);
    logic [12:0] o;
    o = off[12:0];
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'h63};
  endfunction

  function automatic logic [31:0] mk_jal(input longint off);
    logic [20:0] o;
    o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'h6f};
  endfunction

  function automatic logic [31:0] mk_jalr(input longint off);
    logic [11:0] o;
    o = off[11:0];
    return {o, 5'd1, 3'b000, 5'd1, 7'h67};
  endfunction

  // ---- arithmetic reference model
  function automatic void model(input logic [31:0] w, input logic [W-1:0] p,
                                input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] e_next, output logic e_tk,
                                output logic [W-1:0] e_link);
    longint pl, sa, sb, off, ua, ub;
    bit go;
    pl = longint'(p);
    ua = longint'(a);
    ub = longint'(b);
    sa = (ua >= 64'sh80000000) ? ua - 64'sh100000000 : ua;
    sb = (ub >= 64'sh80000000) ? ub - 64'sh100000000 : ub;
    e_link = W'(pl + 4);
    e_next = e_link;
    e_tk   = 1'b0;
    if (w[6:0] == 7'h63) begin
      off = (w[31] ? -4096 : 0) + longint'(w[7]) * 2048
          + longint'(w[30:25]) * 32 + longint'(w[11:8]) * 2;
      case (w[14:12])
        3'd0: go = (ua == ub);
        3'd1: go = (ua != ub);
        3'd4: go = (sa < sb);
        3'd5: go = (sa >= sb);
        3'd6: go = (ua < ub);
        3'd7: go = (ua >= ub);
        default: go = 0;
      endcase
      if (go) begin
        e_tk   = 1'b1;
        e_next = W'(pl + off);
      end
    end else if (w[6:0] == 7'h6f) begin
      off = (w[31] ? -(64'sd1 << 20) : 0) + longint'(w[19:12]) * 4096
          + longint'(w[20]) * 2048 + longint'(w[30:21]) * 2;
      e_tk   = 1'b1;
      e_next = W'(pl + off);
    end else if (w[6:0] == 7'h67) begin
      off = (w[31] ? -2048 : 0) + longint'(w[30:20]);
      e_tk   = 1'b1;
      e_next = W'(((ua + off) / 2) * 2);
      if ((ua + off) < 0) e_next = W'((ua + off) & ~64'sd1);
    end
  endfunction

  task automatic apply(input logic [W-1:0] p, input logic [31:0] w,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input string req);
    logic [W-1:0] e_next, e_link;
    logic e_tk;
    @(posedge clk);
    #2;
    pc = p; ins = w; rs1 = a; rs2 = b;
    model(w, p, a, b, e_next, e_tk, e_link);
    #3;
    n_checks++;
    if (next_pc !== e_next || taken !== e_tk || link_pc !== e_link) begin
      n_fail++;
      $display("FAIL %s: ins=%h pc=%h rs1=%h rs2=%h got next=%h tk=%b link=%h exp next=%h tk=%b link=%h",
               req, w, p, a, b, next_pc, taken, link_pc, e_next, e_tk, e_link);
    end
  endtask

  initial begin
    pc = '0; ins = '0; rs1 = '0; rs2 = '0;
    // R8 idle state: all-zero inputs continue at 4
    apply(32'h0, 32'h0, 32'h0, 32'h0, "R8");
    // R1 equality
    apply(32'h100, mk_br(3'd0, 16), 32'h1234, 32'h1234, "R1");
    apply(32'h100, mk_br(3'd0, 16), 32'h1234, 32'h1235, "R1");
    apply(32'h100, mk_br(3'd1, 16), 32'h1234, 32'h1235, "R1");
    apply(32'h100, mk_br(3'd1, 16), 32'hdead, 32'hdead, "R1");
    // R2 signed ordering across the sign boundary
    apply(32'h200, mk_br(3'd4, -8), 32'h80000000, 32'h1, "R2");
    apply(32'h200, mk_br(3'd5, -8), 32'hffffffff, 32'h1, "R2");
    apply(32'h200, mk_br(3'd5, -8), 32'h7fffffff, 32'h7fffffff, "R2");
    apply(32'h200, mk_br(3'd4, -8), 32'h5, 32'h5, "R2");
    // R3 unsigned ordering on the same operands
    apply(32'h300, mk_br(3'd6, 40), 32'h80000000, 32'h1, "R3");
    apply(32'h300, mk_br(3'd7, 40), 32'hffffffff, 32'h1, "R3");
    apply(32'h300, mk_br(3'd6, 40), 32'h0, 32'hffffffff, "R3");
    // R4 offset extremes and wrap
    apply(32'h4000, mk_br(3'd0, -4096), 32'h0, 32'h0, "R4");
    apply(32'h4000, mk_br(3'd0, 4094), 32'h0, 32'h0, "R4");
    apply(32'h00000010, mk_br(3'd0, -32), 32'h0, 32'h0, "R4");
    // R5 direct jump range and link
    apply(32'h00200000, mk_jal(-(64'sd1 << 20)), 32'h0, 32'h0, "R5");
    apply(32'h00200000, mk_jal((64'sd1 << 20) - 2), 32'h0, 32'h0, "R5");
    apply(32'h00001000, mk_jal(2048), 32'h0, 32'h0, "R5");
    // R6 register-indirect, unscaled offset, bit 0 forced low
    apply(32'h500, mk_jalr(3), 32'h1000, 32'h0, "R6");
    apply(32'h500, mk_jalr(-2048), 32'h1001, 32'h0, "R6");
    apply(32'h500, mk_jalr(0), 32'hffffffff, 32'h0, "R6");
    // R7 link wraps at the top of the address space
    apply(32'hfffffffc, 32'h00000033, 32'h0, 32'h0, "R7");
    apply(32'hfffffffc, mk_jal(8), 32'h0, 32'h0, "R7");
    // R8 reserved branch selectors and other opcodes
    apply(32'h600, mk_br(3'd2, 64), 32'h7, 32'h7, "R8");
    apply(32'h600, mk_br(3'd3, 64), 32'h7, 32'h8, "R8");
    apply(32'h600, 32'h00c58533, 32'h7, 32'h7, "R8");
    // mixed random stream
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [W-1:0] a, b;
      w = $urandom();
      case ($urandom_range(0, 4))
        0, 1: w[6:0] = 7'h63;
        2: w[6:0] = 7'h6f;
        3: w[6:0] = 7'h67;
        default: ;
      endcase
      a = $urandom();
      b = ($urandom_range(0, 3) == 0) ? a : W'($urandom());
      if ($urandom_range(0, 3) == 0) b = a ^ 32'h80000000;
      apply(W'($urandom()), w, a, b, "R1..R8 random");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, got running expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule